// File: doc/BRIEF.md
# Octant Sine-Cosine Symmetry Mapper

This block sits at the end of a quadrature sine/cosine generator. The upstream stage produces sine and cosine values only for a phase folded into the first eighth of the circle. This block turns them into full-circle results using the three top phase bits, called the octant code here. For each octant it either keeps the sine/cosine pairing or swaps the two values. It then negates sine, cosine, both or neither to give the correct quadrant signs.

The mapping is pure logic driven by the octant code. A parameter adds one output register stage that loads on a valid strobe. Negation is saturating, so the most negative 16-bit code maps to the most positive one and never wraps.

Top module: `octant_mapper`

## Requirements
- R1: The two amplitudes are swapped (sine output taken from the cosine input and the reverse) for octant codes 1, 2, 5 and 6, where the code is oct_i read as an unsigned number with bit 2 as MSB; codes 0, 3, 4 and 7 keep the pairing.
- R2: The sine output is the two's complement negation of its selected value for codes 4 to 7, and is not negated for codes 0 to 3.
- R3: The cosine output is the negation of its selected value for codes 2 to 5, and is not negated for codes 0, 1, 6 and 7.
- R4: Negating -32768 (16'h8000) gives +32767 (16'h7FFF) rather than wrapping.
- R5: For code 0 both outputs equal the corresponding inputs unchanged.
- R6: With the output register enabled (default), a sample presented with valid_i high appears on sin_o/cos_o after the next rising clock edge, and valid_o is valid_i delayed by one cycle; during reset all outputs are zero.
- R7: With the output register enabled, a cycle with valid_i low leaves sin_o and cos_o unchanged, whatever the data and code inputs carry.
- R8: When the inputs are the rounded first-octant sine and cosine of a folded phase (folded phase = offset within the octant for even codes, 45 degrees minus that offset for odd codes), the outputs match the rounded full-circle sine and cosine of the true phase to within one LSB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample strobe |
| oct_i | input | 3 | Octant code, three top phase bits |
| sin_i | input | 16 | First-octant sine, signed |
| cos_i | input | 16 | First-octant cosine, signed |
| valid_o | output | 1 | Output sample strobe |
| sin_o | output | 16 | Full-circle sine, signed |
| cos_o | output | 16 | Full-circle cosine, signed |

## Verification
The hardest case to reach is the saturating negation: a real first-octant generator never emits 16'h8000, so no phase-driven stimulus touches it. The bench therefore drives raw amplitude pairs that include the extreme codes together with every octant. This puts the most negative value through every swap and sign combination. A separate phase sweep over all octants checks the folded-phase result against real sine and cosine.

// File: rtl/octmap_pkg.sv
package octmap_pkg;
  typedef struct packed {
    logic swap;
    logic neg_sin;
    logic neg_cos;
  } oct_ctrl_t;
endpackage

// File: rtl/octmap_decode.sv
module octmap_decode
  import octmap_pkg::*;
(
  input  logic [2:0] oct_i,
  output oct_ctrl_t  ctrl_o
);
  always_comb begin
    ctrl_o.swap    = oct_i[1] ^ oct_i[0];
    ctrl_o.neg_sin = oct_i[2];
    ctrl_o.neg_cos = oct_i[2] ^ oct_i[1];
  end

  always_comb begin
    if (!$isunknown(oct_i)) begin
      // R5
      code0_ident_chk: assert (oct_i != 3'd0 || ctrl_o == '0);
    end
  end
endmodule

// File: rtl/octmap_route.sv
module octmap_route #(
  parameter int W = 16
) (
  input  logic         swap_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  always_comb begin
    a_o = swap_i ? b_i : a_i;
    b_o = swap_i ? a_i : b_i;
  end

  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      // R1
      route_pair_chk: assert ((a_o == a_i && b_o == b_i) || (a_o == b_i && b_o == a_i));
    end
  end
endmodule

// File: rtl/octmap_negate.sv
module octmap_negate #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  localparam logic [W-1:0] MinVal = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MaxVal = {1'b0, {(W-1){1'b1}}};

  logic [W-1:0] neg;
  always_comb begin
    neg   = (val_i == MinVal) ? MaxVal : (~val_i + 1'b1);
    val_o = en_i ? neg : val_i;
  end

  logic [W-1:0] sum;
  assign sum = val_o + val_i;

  always_comb begin
    if (!$isunknown({en_i, val_i})) begin
      // R4
      neg_sat_chk: assert (!(en_i && val_i == MinVal) || val_o == MaxVal);
      // R2
      neg_sum_chk: assert (!(en_i && val_i != MinVal) || sum == '0);
      // R5
      neg_pass_chk: assert (en_i || val_o == val_i);
    end
  end
endmodule

// File: rtl/octant_mapper.sv
module octant_mapper
  import octmap_pkg::*;
#(
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [2:0]   oct_i,
  input  logic [W-1:0] sin_i,
  input  logic [W-1:0] cos_i,
  output logic         valid_o,
  output logic [W-1:0] sin_o,
  output logic [W-1:0] cos_o
);
  localparam int NCH = 2;

  oct_ctrl_t    ctrl;
  logic [W-1:0] routed [NCH];
  logic [W-1:0] mapped [NCH];
  logic         neg_en [NCH];

  octmap_decode u_decode (.oct_i(oct_i), .ctrl_o(ctrl));

  octmap_route #(.W(W)) u_route (
    .swap_i(ctrl.swap),
    .a_i   (sin_i),
    .b_i   (cos_i),
    .a_o   (routed[0]),
    .b_o   (routed[1])
  );

  assign neg_en[0] = ctrl.neg_sin;
  assign neg_en[1] = ctrl.neg_cos;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_neg
    octmap_negate #(.W(W)) u_neg (
      .en_i (neg_en[ch]),
      .val_i(routed[ch]),
      .val_o(mapped[ch])
    );
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o <= 1'b0;
        sin_o   <= '0;
        cos_o   <= '0;
      end else begin
        valid_o <= valid_i;
        if (valid_i) begin
          sin_o <= mapped[0];
          cos_o <= mapped[1];
        end
      end
    end

    // R7
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(valid_i) |-> ($stable(sin_o) && $stable(cos_o)));
    // R6
    valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_i |=> valid_o);
  end else begin : g_comb
    assign valid_o = valid_i;
    assign sin_o   = mapped[0];
    assign cos_o   = mapped[1];
  end
endmodule

// File: tb/octant_mapper_bench.sv
module octant_mapper_bench;
  localparam int W = 16;
  localparam real AMP = 32767.0;
  localparam real PI = 3.14159265358979;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [2:0]   oct_i = '0;
  logic [W-1:0] sin_i = '0;
  logic [W-1:0] cos_i = '0;
  logic         valid_o;
  logic [W-1:0] sin_o;
  logic [W-1:0] cos_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  octant_mapper u_octant_mapper (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .oct_i(oct_i),
    .sin_i(sin_i), .cos_i(cos_i), .valid_o(valid_o), .sin_o(sin_o), .cos_o(cos_o)
  );

  function automatic logic [W-1:0] sat_neg(input logic [W-1:0] v);
    if (v == 16'h8000) return 16'h7FFF;
    return 16'(-$signed(v));
  endfunction

  function automatic int rnd(input real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [W-1:0] s, input logic [W-1:0] c);
    @(negedge clk);
    oct_i = o; sin_i = s; cos_i = c; valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // R1 R2 R3 R4 R5: arithmetic model from the requirements
  task automatic exact(input logic [2:0] o, input logic [W-1:0] s, input logic [W-1:0] c);
    logic sw, ns, nc;
    logic [W-1:0] es, ec;
    sw = (o == 3'd1 || o == 3'd2 || o == 3'd5 || o == 3'd6);
    ns = (o >= 3'd4);
    nc = (o >= 3'd2 && o <= 3'd5);
    es = sw ? c : s;
    ec = sw ? s : c;
    if (ns) es = sat_neg(es);
    if (nc) ec = sat_neg(ec);
    drive(o, s, c);
    chk("R6 valid_o", {15'd0, valid_o}, 16'd1);
    if (s == 16'h8000 || c == 16'h8000) begin
      chk("R4 sin", sin_o, es);
      chk("R4 cos", cos_o, ec);
    end else if (o == 3'd0) begin
      chk("R5 sin", sin_o, es);
      chk("R5 cos", cos_o, ec);
    end else begin
      chk("R1/R2 sin", sin_o, es);
      chk("R1/R3 cos", cos_o, ec);
    end
  endtask

  task automatic phase_chk(input int code, input real dlt_deg);
    real f, phi;
    int es, ec, ds, dc;
    f = (code % 2 == 1) ? (45.0 - dlt_deg) : dlt_deg;
    phi = (code * 45.0 + dlt_deg) * PI / 180.0;
    f = f * PI / 180.0;
    drive(3'(code), 16'(rnd(AMP * $sin(f))), 16'(rnd(AMP * $cos(f))));
    es = rnd(AMP * $sin(phi));
    ec = rnd(AMP * $cos(phi));
    ds = int'($signed(sin_o)) - es;
    dc = int'($signed(cos_o)) - ec;
    checks++;
    if (ds > 1 || ds < -1 || dc > 1 || dc < -1) begin
      errors++;
      $display("FAIL R8 code %0d: actual %0d/%0d expected %0d/%0d",
               code, $signed(sin_o), $signed(cos_o), es, ec);
    end
  endtask

  initial begin
    logic [W-1:0] vals [8];
    logic [W-1:0] hs, hc;
    vals = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h5A82, 16'hC000, 16'h1234};
    repeat (2) @(negedge clk);
    // R6 reset state
    chk("R6 reset sin", sin_o, '0);
    chk("R6 reset cos", cos_o, '0);
    chk("R6 reset valid", {15'd0, valid_o}, '0);
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++) begin
      for (int k = 0; k < 8; k++) begin
        exact(3'(o), vals[k], vals[7 - k]);
      end
      exact(3'(o), 16'h8000, 16'h8000);
      exact(3'(o), 16'($urandom), 16'($urandom));
    end
    // R7 hold while valid_i is low
    exact(3'd3, 16'h1111, 16'h2222);
    hs = sin_o; hc = cos_o;
    @(negedge clk);
    oct_i = 3'd6; sin_i = 16'h4321; cos_i = 16'h8765;
    @(posedge clk);
    @(negedge clk);
    chk("R7 sin", sin_o, hs);
    chk("R7 cos", cos_o, hc);
    chk("R6 valid low", {15'd0, valid_o}, '0);
    // R8 phase sweep
    for (int o = 0; o < 8; o++) begin
      phase_chk(o, 0.5);
      phase_chk(o, 10.0);
      phase_chk(o, 22.5);
      phase_chk(o, 37.0);
      phase_chk(o, 44.5);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule